// File: doc/BRIEF.md
# Packed-Lane Integer ALU

This block is a 32-bit integer arithmetic unit whose operands may be split into narrower lanes at run time. A 2-bit packing selector makes the unit treat each operand as one full word, as two half-word lanes, or as four byte lanes. Every operation runs on each lane on its own. Carries, borrows and product bits never cross from one lane into the next.

The operation set has three groups. The arithmetic group is add, subtract, and multiply keeping the low lane bits. The logic group is AND, OR and XOR. The third group is signed minimum and maximum, plus three compares: equal, signed less-than and unsigned less-than. A compare fills each lane with all ones when its condition holds and with all zeros when it does not. The result can therefore be ANDed straight onto data to clear the lanes that failed. The datapath is combinational. A parameter can add one output register stage.

Top module: `lane_alu`

## Requirements
- R1: Packing codes on `mode_i` are 2'b00 one 32-bit lane, 2'b01 two 16-bit lanes (bits 15:0 and 31:16), 2'b10 four 8-bit lanes (lane k at bits 8k+7:8k). Opcode 4'd0 adds per lane modulo the lane width, with no carry between lanes.
- R2: Opcode 4'd1 computes a minus b per lane modulo the lane width, with no borrow between lanes.
- R3: Opcode 4'd2 yields the low lane-width bits of the per-lane product a times b.
- R4: Opcodes 4'd3, 4'd4 and 4'd5 (AND, OR, XOR) give the same bitwise result in every legal packing.
- R5: Opcode 4'd6 gives the signed per-lane minimum and opcode 4'd7 gives the signed per-lane maximum. Lanes are two's complement at the lane width.
- R6: Opcode 4'd8 sets a lane to all ones when its a and b lanes are equal, and to all zeros otherwise.
- R7: Opcode 4'd9 sets a lane to all ones when the a lane is less than the b lane as two's complement at the lane width, and to all zeros otherwise.
- R8: Opcode 4'd10 is the same compare as opcode 4'd9, but treats the lanes as unsigned.
- R9: ANDing a value with a compare result (opcode 4'd3) keeps the lanes whose compare was true and clears the others.
- R10: Packing code 2'b11 is reserved. With it, the result is zero and `illegal_o` is 1 for any opcode. In every legal packing, `illegal_o` is 0.
- R11: Opcodes 4'd11 to 4'd15 give a zero result with `illegal_o` 0.
- R12: With REG_OUT=1, the outputs show the result for the inputs present at the previous rising clock edge, and reset forces them to zero. With REG_OUT=0, the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Packing selector |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Lane-wise result |
| illegal_o | output | 1 | Reserved packing code was used |

## Verification
The bench builds two copies of the block side by side. One uses REG_OUT=1 and the other REG_OUT=0, and both see the same stimulus. This exercises the one-cycle registered timing, the reset value and the purely combinational path in the same run. Both copies use the default 32-bit width. At that width the byte lanes are narrow enough for random operands to hit equal lanes, sign-bit boundaries and lane-edge carries often.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  typedef enum logic [1:0] {
    PACK_WORD = 2'd0,
    PACK_HALF = 2'd1,
    PACK_BYTE = 2'd2,
    PACK_RSVD = 2'd3
  } pack_e;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_MIN  = 4'd6,
    OP_MAX  = 4'd7,
    OP_SEQ  = 4'd8,
    OP_SLT  = 4'd9,
    OP_SLTU = 4'd10,
    OP_R11  = 4'd11,
    OP_R12  = 4'd12,
    OP_R13  = 4'd13,
    OP_R14  = 4'd14,
    OP_R15  = 4'd15
  } alu_op_e;

  function automatic logic is_bitwise(alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction
endpackage

// File: rtl/lane_alu_lanes.sv
// Arithmetic, min/max and compare for one fixed lane width.
module lane_alu_lanes
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned NUM_LANES = DATA_W / LANE_W;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] la, lb, sum, diff, prod, lres;
    logic lt_s, lt_u, eq;

    assign la   = a_i[l*LANE_W +: LANE_W];
    assign lb   = b_i[l*LANE_W +: LANE_W];
    assign sum  = la + lb;
    assign diff = la - lb;
    assign prod = la * lb;
    assign lt_s = $signed(la) < $signed(lb);
    assign lt_u = la < lb;
    assign eq   = la == lb;

    always_comb begin
      unique case (op_i)
        OP_ADD:  lres = sum;
        OP_SUB:  lres = diff;
        OP_MUL:  lres = prod;
        OP_MIN:  lres = lt_s ? la : lb;
        OP_MAX:  lres = lt_s ? lb : la;
        OP_SEQ:  lres = {LANE_W{eq}};
        OP_SLT:  lres = {LANE_W{lt_s}};
        OP_SLTU: lres = {LANE_W{lt_u}};
        default: lres = '0;
      endcase
    end

    assign res_o[l*LANE_W +: LANE_W] = lres;
  end
endmodule

// File: rtl/lane_alu_out.sv
// Optional output register.
module lane_alu_out #(
  parameter int unsigned WIDTH   = 33,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= '0;
      else         q_o <= d_i;
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign q_o = d_i;
  end
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned BYTE_W = DATA_W / 4;

  alu_op_e op;
  pack_e   mode;
  assign op   = alu_op_e'(op_i);
  assign mode = pack_e'(mode_i);

  logic [DATA_W-1:0] res_word, res_half, res_byte, res_bit, res_nxt;
  logic              ill_nxt;

  lane_alu_lanes #(.DATA_W(DATA_W), .LANE_W(DATA_W)) u_word (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(res_word)
  );
  lane_alu_lanes #(.DATA_W(DATA_W), .LANE_W(HALF_W)) u_half (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(res_half)
  );
  lane_alu_lanes #(.DATA_W(DATA_W), .LANE_W(BYTE_W)) u_byte (
    .a_i(a_i), .b_i(b_i), .op_i(op), .res_o(res_byte)
  );

  // Bitwise ops ignore lane boundaries.
  always_comb begin
    unique case (op)
      OP_AND:  res_bit = a_i & b_i;
      OP_OR:   res_bit = a_i | b_i;
      OP_XOR:  res_bit = a_i ^ b_i;
      default: res_bit = '0;
    endcase
  end

  always_comb begin
    ill_nxt = (mode == PACK_RSVD);
    res_nxt = '0;
    if (!ill_nxt) begin
      if (is_bitwise(op)) begin
        res_nxt = res_bit;
      end else begin
        unique case (mode)
          PACK_HALF: res_nxt = res_half;
          PACK_BYTE: res_nxt = res_byte;
          default:   res_nxt = res_word;
        endcase
      end
    end
  end

  lane_alu_out #(.WIDTH(DATA_W + 1), .REG_OUT(REG_OUT)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ill_nxt, res_nxt}),
    .q_o   ({illegal_o, result_o})
  );
endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [3:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] result_o,
  input logic              illegal_o
);
  logic [1:0]        mode_q;
  logic [3:0]        op_q;
  logic [DATA_W-1:0] a_q, b_q;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q <= '0; op_q <= '0; a_q <= '0; b_q <= '0;
      end else begin
        mode_q <= mode_i; op_q <= op_i; a_q <= a_i; b_q <= b_i;
      end
    end
  end else begin : g_nodly
    assign mode_q = mode_i;
    assign op_q   = op_i;
    assign a_q    = a_i;
    assign b_q    = b_i;
  end

  function automatic logic is_mask(logic [DATA_W-1:0] r, logic [1:0] m);
    int unsigned w;
    logic ok;
    w  = (m == 2'd2) ? DATA_W / 4 : (m == 2'd1) ? DATA_W / 2 : DATA_W;
    ok = 1'b1;
    for (int unsigned i = 0; i < DATA_W; i++)
      if (r[i] != r[(i / w) * w]) ok = 1'b0;
    return ok;
  endfunction

  p_illegal_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o == (mode_q == 2'd3));

  p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> result_o == '0);

  p_unassigned_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q > 4'd10) |-> result_o == '0);

  p_byte_add_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'd2 && op_q == 4'd0) |->
      result_o[DATA_W/4-1:0] == a_q[DATA_W/4-1:0] + b_q[DATA_W/4-1:0]);

  p_xor_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 2'd3 && op_q == 4'd5) |-> result_o == (a_q ^ b_q));

  p_eq_self_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != 2'd3 && op_q == 4'd8 && a_q == b_q) |-> result_o == '1);

  p_cmp_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q >= 4'd8 && op_q <= 4'd10) |-> is_mask(result_o, mode_q));
endmodule

bind lane_alu lane_alu_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_lane_alu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .result_o(result_o), .illegal_o(illegal_o)
);

// File: tb/lane_alu_test.sv
module lane_alu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode = '0;
  logic [3:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [31:0] res_r, res_c;
  logic        ill_r, ill_c;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lane_alu #(.DATA_W(32), .REG_OUT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .op_i(op), .a_i(a), .b_i(b),
    .result_o(res_r), .illegal_o(ill_r)
  );
  lane_alu #(.DATA_W(32), .REG_OUT(1'b0)) uut_comb (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .op_i(op), .a_i(a), .b_i(b),
    .result_o(res_c), .illegal_o(ill_c)
  );

  // Reference model: returns {illegal, result}.
  function automatic logic [32:0] model(logic [1:0] m, logic [3:0] o,
                                        logic [31:0] x, logic [31:0] y);
    logic [31:0] r, msk, sb, la, lb, lr;
    int w;
    if (m == 2'd3) return {1'b1, 32'h0};
    case (o)
      4'd3: return {1'b0, x & y};
      4'd4: return {1'b0, x | y};
      4'd5: return {1'b0, x ^ y};
      default: ;
    endcase
    w   = (m == 2'd2) ? 8 : (m == 2'd1) ? 16 : 32;
    msk = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
    sb  = 32'h1 << (w - 1);
    r   = '0;
    for (int k = 0; k < 32 / w; k++) begin
      la = (x >> (k * w)) & msk;
      lb = (y >> (k * w)) & msk;
      case (o)
        4'd0:  lr = la + lb;
        4'd1:  lr = la - lb;
        4'd2:  lr = la * lb;
        4'd6:  lr = ((la ^ sb) < (lb ^ sb)) ? la : lb;
        4'd7:  lr = ((la ^ sb) < (lb ^ sb)) ? lb : la;
        4'd8:  lr = (la == lb) ? msk : 32'h0;
        4'd9:  lr = ((la ^ sb) < (lb ^ sb)) ? msk : 32'h0;
        4'd10: lr = (la < lb) ? msk : 32'h0;
        default: lr = '0;
      endcase
      r = r | ((lr & msk) << (k * w));
    end
    return {1'b0, r};
  endfunction

  task automatic check(bit ok, string tag, logic [32:0] act, logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check comb copy at once and registered copy after the next edge.
  task automatic apply(logic [1:0] m, logic [3:0] o, logic [31:0] x, logic [31:0] y,
                       string tag);
    logic [32:0] e;
    @(negedge clk);
    mode = m; op = o; a = x; b = y;
    e = model(m, o, x, y);
    #1;
    check({ill_c, res_c} === e, tag, {ill_c, res_c}, e);
    @(posedge clk);
    #1;
    check({ill_r, res_r} === e, tag, {ill_r, res_r}, e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] cm, e;
    void'($urandom(32'd20240611));
    // R12: reset holds registered outputs at zero.
    mode = 2'd3; op = 4'd0; a = 32'hDEAD_BEEF; b = 32'h1234_5678;
    repeat (3) @(posedge clk);
    #1;
    check({ill_r, res_r} === 33'h0, "R12 reset", {ill_r, res_r}, 33'h0);
    @(negedge clk); rst_ni = 1'b1;

    // R12: registered output lags by one edge.
    @(negedge clk); mode = 2'd0; op = 4'd0; a = 32'd5; b = 32'd7;
    #1;
    check(res_r === 32'h0, "R12 lag", {ill_r, res_r}, 33'h0);
    check(res_c === 32'd12, "R12 comb", {ill_c, res_c}, 33'd12);
    @(posedge clk); #1;
    check(res_r === 32'd12, "R12 reg", {ill_r, res_r}, 33'd12);

    apply(2'd2, 4'd0, 32'hFFFF_FFFF, 32'h0101_0101, "R1 byte carry kill");
    apply(2'd1, 4'd0, 32'h0000_FFFF, 32'h0000_0001, "R1 half carry kill");
    apply(2'd0, 4'd0, 32'h0000_FFFF, 32'h0000_0001, "R1 word carry");
    apply(2'd2, 4'd1, 32'h0000_0000, 32'h0101_0101, "R2 byte borrow");
    apply(2'd1, 4'd1, 32'h0001_0000, 32'h0000_0001, "R2 half borrow");
    apply(2'd2, 4'd2, 32'h8010_FF03, 32'h0210_FF05, "R3 byte mul");
    apply(2'd1, 4'd2, 32'h8000_1234, 32'h0002_0100, "R3 half mul");
    apply(2'd0, 4'd2, 32'h0001_0001, 32'h0001_0001, "R3 word mul");
    apply(2'd2, 4'd5, 32'hF0F0_1234, 32'h0FF0_FFFF, "R4 xor byte");
    apply(2'd1, 4'd3, 32'hF0F0_1234, 32'h0FF0_FFFF, "R4 and half");
    apply(2'd0, 4'd4, 32'hF0F0_1234, 32'h0FF0_0000, "R4 or word");
    apply(2'd2, 4'd6, 32'h807F_0102, 32'h7F80_0201, "R5 min byte");
    apply(2'd1, 4'd7, 32'h8000_7FFF, 32'h7FFF_8000, "R5 max half");
    apply(2'd2, 4'd8, 32'h1122_3344, 32'h1100_3300, "R6 seq byte");
    apply(2'd2, 4'd9, 32'h807F_0000, 32'h7F80_0000, "R7 slt byte sign");
    apply(2'd1, 4'd9, 32'h8000_0001, 32'h0001_0002, "R7 slt half");
    apply(2'd2, 4'd10, 32'h807F_0000, 32'h7F80_0000, "R8 sltu byte");
    apply(2'd0, 4'd10, 32'h0000_0001, 32'hFFFF_FFFF, "R8 sltu word");
    apply(2'd3, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10 reserved add");
    apply(2'd3, 4'd5, 32'h1234_5678, 32'h0, "R10 reserved xor");
    apply(2'd2, 4'd12, 32'h1234_5678, 32'h9ABC_DEF0, "R11 unassigned");
    apply(2'd0, 4'd15, 32'hFFFF_FFFF, 32'h1, "R11 unassigned");

    // R9: compare mask then AND with it.
    apply(2'd2, 4'd9, 32'h0590_64C8, {4{8'd100}}, "R9 mask build");
    cm = res_r;
    e  = 32'hA1B2_C3D4 & model(2'd2, 4'd9, 32'h0590_64C8, {4{8'd100}});
    apply(2'd2, 4'd3, 32'hA1B2_C3D4, cm, "R9 masked and");
    check(res_r === e, "R9 lanes zeroed", {1'b0, res_r}, {1'b0, e});

    for (int i = 0; i < 400; i++) begin
      logic [1:0] m;
      logic [3:0] o;
      logic [31:0] x, y;
      m = 2'($urandom % 4);
      o = 4'($urandom % 16);
      x = $urandom;
      y = ($urandom % 4 == 0) ? (x ^ (32'hFF << (8 * ($urandom % 4)))) : $urandom;
      case (o)
        4'd0: apply(m, o, x, y, "R1 random");
        4'd1: apply(m, o, x, y, "R2 random");
        4'd2: apply(m, o, x, y, "R3 random");
        4'd3, 4'd4, 4'd5: apply(m, o, x, y, "R4 random");
        4'd6, 4'd7: apply(m, o, x, y, "R5 random");
        4'd8: apply(m, o, x, y, "R6 random");
        4'd9: apply(m, o, x, y, "R7 random");
        4'd10: apply(m, o, x, y, "R8 random");
        default: apply(m, o, x, y, "R11 random");
      endcase
    end
    finish_run();
  end
endmodule